// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Two-Chip Cascade

This block collects interrupt requests from peripherals, picks the most urgent one by a fixed priority order and raises one interrupt line towards the processor. The processor answers with two acknowledge pulses. The first pulse freezes the choice and marks the chosen level as being serviced. The second pulse returns an 8-bit vector that identifies the handler. The controller keeps a record of which levels are in service. While a handler runs, only a strictly more urgent request can break in. An end-of-interrupt pulse releases the most urgent level in service.

Two identical controller units can be chained. The secondary unit's interrupt output feeds input 2 of the primary unit, which gives 15 usable request lines. For any acknowledge that resolves to input 2, the primary stays off the vector bus and the secondary supplies the vector. A request raised on line 2 is steered to level 9 (secondary input 1), so legacy sources that use that line still work.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset `intr_o` and `vec_valid_o` are low and `vec_o` is zero.
- R2: A request is captured on a rising edge of its `req_i` bit. Among the pending eligible requests of a unit, the lowest index wins. `intr_o` goes high while a winner exists and no acknowledge is in progress.
- R3: Acknowledge takes two single-cycle `inta_i` pulses. After the second pulse, `vec_valid_o` is high for exactly one cycle with `vec_o` = {5-bit base, 3-bit index}, and the serviced request is cleared.
- R4: While a level is in service, requests of equal or lower priority (equal or larger index) are held pending and do not raise `intr_o`. A request of strictly higher priority does raise it.
- R5: A pulse on `eoi_pri_i` or `eoi_sec_i` clears only the lowest-index in-service level of that unit. Held requests that become eligible then raise `intr_o`.
- R6: With cascading enabled, `req_i[15:8]` are secondary lines 0 to 7. Their vector is {`base_sec_i`, line-8}, and the primary never places a vector whose index is 2.
- R7: A rising edge on `req_i[2]` is serviced as level 9 and yields vector {`base_sec_i`, 3'd1}.
- R8: While a secondary level is in service, primary lines 0 and 1 can preempt it, and primary lines 3 to 7 wait until both units have received an end-of-interrupt.
- R9: A request held high does not re-interrupt after it has been acknowledged. It needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Request lines: [7:0] primary, [15:8] secondary |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| eoi_pri_i | input | 1 | End-of-interrupt pulse for the primary unit |
| eoi_sec_i | input | 1 | End-of-interrupt pulse for the secondary unit |
| base_pri_i | input | 5 | Vector base of the primary unit |
| base_sec_i | input | 5 | Vector base of the secondary unit |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector returned on the second acknowledge |
| vec_valid_o | output | 1 | One-cycle strobe qualifying `vec_o` |

## Verification
The bench raises several requests at once and checks the vector order. A design that encoded the highest index instead of the lowest would return the vectors in reverse. Nesting is probed with requests of equal, lower and higher priority while a level is in service. A wrong comparison would let an equal-priority request break in, or would block a more urgent one. A chain of two end-of-interrupts then checks that only the top in-service bit is released each time. The cascade cases cover a secondary line, the line-2 reroute and a primary preemption of a cascaded handler. A primary that also drove the bus for line 2 would show up as a corrupted vector. A held request line checks that the controller does not loop on the same interrupt.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int IRQ_LINES      = 8;
  localparam int IRQ_BASE_W     = 5;
  localparam int IRQ_CAS_LINE   = 2;
  localparam int IRQ_REMAP_LINE = 1;

  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_ARMED = 1'b1
  } ack_phase_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Lowest set index wins; any_o flags a non-empty input.
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_nest_mask.sv
// allow_o[i] is set when no line of equal or higher priority is in service.
module irq_nest_mask #(
  parameter int N = 8
) (
  input  logic [N-1:0] isr_i,
  output logic [N-1:0] allow_o
);
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      blocked    = blocked | isr_i[i];
      allow_o[i] = ~blocked;
    end
  end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_cascade_pkg::*;
#(
  parameter int          N          = IRQ_LINES,
  parameter int          BW         = IRQ_BASE_W,
  parameter bit          DEFER_EN   = 1'b0,
  parameter int          DEFER_LINE = IRQ_CAS_LINE,
  parameter logic [N-1:0] LEVEL_MASK = '0,
  parameter int          IW         = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          ack_i,
  input  logic          ack_en_i,
  input  logic          eoi_i,
  input  logic [BW-1:0] base_i,
  output logic          int_o,
  output logic [BW+IW-1:0] vec_o,
  output logic          vec_vld_o,
  output logic          defer_hit_o,
  output logic [N-1:0]  isr_o
);
  localparam logic [IW-1:0] DL = IW'(DEFER_LINE);

  logic [N-1:0]  req_q, irr_q, isr_q, isr_n, allow, elig;
  ack_phase_e    phase_q;
  logic          frz_vld_q;
  logic [IW-1:0] frz_idx_q;
  logic [IW-1:0] win_idx, top_idx;
  logic          win_any, top_any;
  logic          take, first, second, own_vec;
  logic          int_q, vld_q;
  logic [BW+IW-1:0] vec_q;

  irq_nest_mask #(.N(N)) u_mask (.isr_i(isr_q), .allow_o(allow));

  assign elig = irr_q & allow;

  irq_prio_pick #(.N(N), .IW(IW)) u_win (.vec_i(elig),  .idx_o(win_idx), .any_o(win_any));
  irq_prio_pick #(.N(N), .IW(IW)) u_top (.vec_i(isr_q), .idx_o(top_idx), .any_o(top_any));

  assign take    = ack_i & ack_en_i;
  assign first   = take & (phase_q == ACK_IDLE);
  assign second  = take & (phase_q == ACK_ARMED);
  assign own_vec = frz_vld_q & ~(DEFER_EN & (frz_idx_q == DL));

  always_comb begin
    isr_n = isr_q;
    if (eoi_i && top_any) isr_n[top_idx] = 1'b0;
    if (first && win_any) isr_n[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      phase_q   <= ACK_IDLE;
      frz_vld_q <= 1'b0;
      frz_idx_q <= '0;
      int_q     <= 1'b0;
      vld_q     <= 1'b0;
      vec_q     <= '0;
    end else begin
      req_q <= req_i;
      for (int i = 0; i < N; i++) begin
        if (LEVEL_MASK[i]) begin
          irr_q[i] <= req_i[i];
        end else if (req_i[i] && !req_q[i]) begin
          irr_q[i] <= 1'b1;
        end else if (second && frz_vld_q && frz_idx_q == IW'(i)) begin
          irr_q[i] <= 1'b0;
        end
      end
      isr_q <= isr_n;
      if (first) begin
        phase_q   <= ACK_ARMED;
        frz_vld_q <= win_any;
        frz_idx_q <= win_idx;
      end else if (second) begin
        phase_q   <= ACK_IDLE;
        frz_vld_q <= 1'b0;
      end
      int_q <= win_any && (phase_q == ACK_IDLE) && !first;
      vld_q <= second && own_vec;
      vec_q <= (second && own_vec) ? {base_i, frz_idx_q} : '0;
    end
  end

  assign defer_hit_o = DEFER_EN &&
                       ((phase_q == ACK_ARMED) ? (frz_vld_q && frz_idx_q == DL)
                                               : (win_any && win_idx == DL));
  assign int_o     = int_q;
  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
  assign isr_o     = isr_q;
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter bit CASCADE_EN = 1'b1,
  parameter int N_LINES    = IRQ_LINES,
  parameter int BASE_W     = IRQ_BASE_W,
  parameter int CAS_LINE   = IRQ_CAS_LINE,
  parameter int REMAP_LINE = IRQ_REMAP_LINE,
  parameter int VEC_W      = BASE_W + $clog2(N_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*N_LINES-1:0] req_i,
  input  logic                 inta_i,
  input  logic                 eoi_pri_i,
  input  logic                 eoi_sec_i,
  input  logic [BASE_W-1:0]    base_pri_i,
  input  logic [BASE_W-1:0]    base_sec_i,
  output logic                 intr_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o
);
  localparam logic [N_LINES-1:0] PRI_LEVEL =
    CASCADE_EN ? (N_LINES'(1) << CAS_LINE) : '0;

  logic [N_LINES-1:0] pri_req, sec_req, pri_isr, sec_isr;
  logic               pri_int, sec_int, pri_hit, sec_hit, sec_ack_en;
  logic               pri_vld, sec_vld;
  logic [VEC_W-1:0]   pri_vec, sec_vec;

  generate
    if (CASCADE_EN) begin : g_cas
      always_comb begin
        pri_req           = req_i[N_LINES-1:0];
        pri_req[CAS_LINE] = sec_int;
        sec_req           = req_i[2*N_LINES-1:N_LINES];
        sec_req[REMAP_LINE] = sec_req[REMAP_LINE] | req_i[CAS_LINE];
      end
      // The secondary follows the primary only on acknowledges that resolve
      // to the cascade input. sec_hit would only hand the cycle further down
      // a longer chain, so with two units it never gates anything.
      assign sec_ack_en = pri_hit & ~sec_hit;

      irq_prio_unit #(
        .N(N_LINES), .BW(BASE_W), .DEFER_EN(1'b0),
        .DEFER_LINE(CAS_LINE), .LEVEL_MASK('0)
      ) u_sec (
        .clk(clk), .rst(rst), .req_i(sec_req),
        .ack_i(inta_i), .ack_en_i(sec_ack_en), .eoi_i(eoi_sec_i),
        .base_i(base_sec_i), .int_o(sec_int), .vec_o(sec_vec),
        .vec_vld_o(sec_vld), .defer_hit_o(sec_hit), .isr_o(sec_isr)
      );
    end else begin : g_single
      assign pri_req    = req_i[N_LINES-1:0];
      assign sec_req    = '0;
      assign sec_int    = 1'b0;
      assign sec_hit    = 1'b0;
      assign sec_ack_en = 1'b0;
      assign sec_vec    = '0;
      assign sec_vld    = 1'b0;
      assign sec_isr    = '0;
    end
  endgenerate

  irq_prio_unit #(
    .N(N_LINES), .BW(BASE_W), .DEFER_EN(CASCADE_EN),
    .DEFER_LINE(CAS_LINE), .LEVEL_MASK(PRI_LEVEL)
  ) u_pri (
    .clk(clk), .rst(rst), .req_i(pri_req),
    .ack_i(inta_i), .ack_en_i(1'b1), .eoi_i(eoi_pri_i),
    .base_i(base_pri_i), .int_o(pri_int), .vec_o(pri_vec),
    .vec_vld_o(pri_vld), .defer_hit_o(pri_hit), .isr_o(pri_isr)
  );

  // Both vector registers hold zero unless their strobe is set.
  assign intr_o      = pri_int;
  assign vec_o       = pri_vec | sec_vec;
  assign vec_valid_o = pri_vld | sec_vld;
endmodule

// File: rtl/irq_cascade_ctrl_sva.sv
module irq_cascade_ctrl_sva #(
  parameter bit CASCADE_EN = 1'b1,
  parameter int N_LINES    = 8,
  parameter int BASE_W     = 5,
  parameter int CAS_LINE   = 2,
  parameter int VEC_W      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inta_i,
  input logic               eoi_pri_i,
  input logic               eoi_sec_i,
  input logic [BASE_W-1:0]  base_pri_i,
  input logic [BASE_W-1:0]  base_sec_i,
  input logic               intr_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_valid_o,
  input logic [N_LINES-1:0] pri_isr,
  input logic [N_LINES-1:0] sec_isr
);
  localparam int IW = VEC_W - BASE_W;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!intr_o && !vec_valid_o && vec_o == '0));

  p_vec_single_r3: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |=> !vec_valid_o);

  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(inta_i));

  p_eoi_one_pri_r5: assert property (@(posedge clk) disable iff (rst)
    (eoi_pri_i && !inta_i && pri_isr != '0) |=>
      ($countones(pri_isr) + 1 == $countones($past(pri_isr))));

  p_eoi_one_sec_r5: assert property (@(posedge clk) disable iff (rst)
    (eoi_sec_i && !inta_i && sec_isr != '0) |=>
      ($countones(sec_isr) + 1 == $countones($past(sec_isr))));

  p_vec_owner_r6: assert property (@(posedge clk) disable iff (rst)
    (CASCADE_EN && vec_valid_o) |->
      ((vec_o[VEC_W-1:IW] == base_pri_i && vec_o[IW-1:0] != IW'(CAS_LINE)) ||
       vec_o[VEC_W-1:IW] == base_sec_i));
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_sva #(
  .CASCADE_EN(CASCADE_EN), .N_LINES(N_LINES), .BASE_W(BASE_W),
  .CAS_LINE(CAS_LINE), .VEC_W(VEC_W)
) u_sva (
  .clk(clk), .rst(rst), .inta_i(inta_i), .eoi_pri_i(eoi_pri_i),
  .eoi_sec_i(eoi_sec_i), .base_pri_i(base_pri_i), .base_sec_i(base_sec_i),
  .intr_o(intr_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o),
  .pri_isr(pri_isr), .sec_isr(sec_isr)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] BP = 5'h10;   // primary vectors 0x80 + line
  localparam logic [4:0] BS = 5'h18;   // secondary vectors 0xC0 + line

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_i = '0;
  logic        inta_i = 1'b0, eoi_pri_i = 1'b0, eoi_sec_i = 1'b0;
  logic        intr_o, vec_valid_o;
  logic [7:0]  vec_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_ctrl uut (
    .clk(clk), .rst(rst), .req_i(req_i), .inta_i(inta_i),
    .eoi_pri_i(eoi_pri_i), .eoi_sec_i(eoi_sec_i),
    .base_pri_i(BP), .base_sec_i(BS),
    .intr_o(intr_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: every vector strobe must match the next expected item.
  always @(negedge clk) begin
    if (!rst && vec_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected vector", vec_o, 8'hxx);
      end else begin
        check(tag_q.pop_front(), vec_o, exp_q.pop_front());
      end
    end
  end

  task automatic pulse_req(input int line);
    @(negedge clk) req_i[line] = 1'b1;
    @(negedge clk) req_i[line] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk) inta_i = 1'b1;
    @(negedge clk) inta_i = 1'b0;
    @(negedge clk) inta_i = 1'b1;
    @(negedge clk) inta_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic eoi(input bit pri, input bit sec);
    @(negedge clk) begin eoi_pri_i = pri; eoi_sec_i = sec; end
    @(negedge clk) begin eoi_pri_i = 1'b0; eoi_sec_i = 1'b0; end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 intr after reset", {7'd0, intr_o}, 8'd0);
    check("R1 strobe after reset", {7'd0, vec_valid_o}, 8'd0);
    check("R1 vector after reset", vec_o, 8'd0);

    // R2: two simultaneous requests, lowest index first
    @(negedge clk) begin req_i[5] = 1'b1; req_i[3] = 1'b1; end
    @(negedge clk) begin req_i[5] = 1'b0; req_i[3] = 1'b0; end
    repeat (6) @(negedge clk);
    check("R2 intr raised", {7'd0, intr_o}, 8'd1);
    ack(8'h83, "R2 winner line 3");
    check("R4 line 5 held behind 3", {7'd0, intr_o}, 8'd0);
    eoi(1'b1, 1'b0);
    check("R5 line 5 released", {7'd0, intr_o}, 8'd1);
    ack(8'h85, "R3 vector line 5");
    eoi(1'b1, 1'b0);

    // R9: held request does not repeat
    @(negedge clk) req_i[6] = 1'b1;
    repeat (6) @(negedge clk);
    ack(8'h86, "R9 held line 6");
    eoi(1'b1, 1'b0);
    check("R9 no repeat while held", {7'd0, intr_o}, 8'd0);
    @(negedge clk) req_i[6] = 1'b0;

    // R4/R5: nesting
    pulse_req(4);
    ack(8'h84, "R4 line 4");
    pulse_req(6);
    check("R4 lower held", {7'd0, intr_o}, 8'd0);
    pulse_req(4);
    check("R4 equal held", {7'd0, intr_o}, 8'd0);
    pulse_req(1);
    check("R4 higher preempts", {7'd0, intr_o}, 8'd1);
    ack(8'h81, "R4 preempting line 1");
    eoi(1'b1, 1'b0);
    check("R5 only top cleared", {7'd0, intr_o}, 8'd0);
    eoi(1'b1, 1'b0);
    check("R5 second eoi releases", {7'd0, intr_o}, 8'd1);
    ack(8'h84, "R5 line 4 again");
    eoi(1'b1, 1'b0);
    ack(8'h86, "R5 line 6 last");
    eoi(1'b1, 1'b0);
    check("R5 all served", {7'd0, intr_o}, 8'd0);

    // R6: secondary line 12 -> secondary index 4
    pulse_req(12);
    check("R6 cascade intr", {7'd0, intr_o}, 8'd1);
    ack(8'hC4, "R6 secondary vector");
    eoi(1'b1, 1'b1);

    // R7: line 2 rerouted to level 9
    pulse_req(2);
    check("R7 rerouted intr", {7'd0, intr_o}, 8'd1);
    ack(8'hC1, "R7 level 9 vector");
    eoi(1'b1, 1'b1);

    // R8: primary preemption of a cascaded handler
    pulse_req(13);
    ack(8'hC5, "R8 secondary line 13");
    pulse_req(3);
    check("R8 line 3 held", {7'd0, intr_o}, 8'd0);
    pulse_req(0);
    check("R8 line 0 preempts", {7'd0, intr_o}, 8'd1);
    ack(8'h80, "R8 line 0 vector");
    eoi(1'b1, 1'b0);
    check("R8 line 3 still held", {7'd0, intr_o}, 8'd0);
    eoi(1'b0, 1'b1);
    eoi(1'b1, 1'b0);
    check("R8 line 3 released", {7'd0, intr_o}, 8'd1);
    ack(8'h83, "R8 line 3 vector");
    eoi(1'b1, 1'b0);

    check("R3 all vectors seen", 8'(exp_q.size()), 8'd0);
    finish_run();
  end
endmodule